// File: doc/BRIEF.md
# Stereogram Pixel Separation Calculator

This block turns one depth-map sample into the pair of screen columns that a random-dot stereogram must tie together. Every sample carries a column `x`, a line `y` and an 8-bit height `z`. Height 0 is the flat background and the largest height is the point closest to the viewer. Three static settings, all counted in pixels, describe the viewing geometry: the depth of the background plane behind the screen, the distance from the viewer to the screen, and the spacing between the viewer's eyes.

The block is a three-stage pipeline and takes a new sample on every clock. In the first stage the sample's distance behind the screen is found, and from it the numerator and the denominator of the separation ratio, each held in its own register. In the second stage the numerator is divided by the denominator. In the third stage half the separation is placed on each side of the sample column, giving a left and a right column, and a flag marks any pair that falls off the screen so that the linking logic further on can skip it. The sample's `x`, `y` and `z` move through the stages beside the result, so a downstream stage always sees them with their own separation.

Top module: `stereo_sep_calc`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and every data output (`outX`, `outY`, `outZ`, `outSep`, `outLeft`, `outRight`, `outOfRange`) is 0.
- R2: `outSep` = floor((N + floor(Q/2)) / Q), with depth d = max(`bgDepth` − HEIGHT_SCALE·z, 0), N = d·`eyeSep` and Q = `obsDist` + d. This is the ratio rounded half up. When Q = 0 the separation is 0. The result never exceeds `eyeSep`.
- R3: With h = floor(`outSep`/2), `outRight` = x + h and `outLeft` = x − h.
- R4: `outOfRange` is 1 exactly when x < h or x + h > SCREEN_W − 1 (639 by default). While it is 1, `outLeft` and `outRight` carry no meaning.
- R5: `outValid` equals `inValid` from exactly 3 clock edges earlier. A new sample is taken on every edge, so back-to-back samples come out on consecutive cycles.
- R6: `outX`, `outY` and `outZ` are the `x`, `y` and `z` of the same sample whose separation is on `outSep`.
- R7: Height 0 gives the widest separation for the given settings. A height with HEIGHT_SCALE·z ≥ `bgDepth` gives separation 0, so `outLeft` = `outRight` = x.
- R8: A cycle with `inValid` low loads nothing. When no valid sample has entered for 3 cycles, every data output holds the value of the last valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample on the inputs is valid this cycle |
| inX | input | X_W (10) | Sample column |
| inY | input | Y_W (9) | Sample line |
| inZ | input | Z_W (8) | Sample height, 0 = background |
| bgDepth | input | DIST_W (12) | Background plane depth behind the screen, pixels |
| obsDist | input | DIST_W (12) | Viewer distance from the screen, pixels |
| eyeSep | input | SEP_W (10) | Eye spacing, pixels |
| outValid | output | 1 | Result valid |
| outX | output | X_W | Column carried with the result |
| outY | output | Y_W | Line carried with the result |
| outZ | output | Z_W | Height carried with the result |
| outSep | output | SEP_W | Separation of the linked pixel pair |
| outLeft | output | X_W | Left linked column |
| outRight | output | X_W | Right linked column |
| outOfRange | output | 1 | Pair falls outside the screen |

## Verification
Every result of a sample (separation, left and right columns, range flag and carried coordinates) reaches the outputs on the third clock edge after the edge that takes the sample in. The bench drives inputs on the falling edge and reads outputs on the falling edge three cycles after the drive. It does this both for a stream of back-to-back samples and for an isolated pulse, and in the pulse case it confirms that `outValid` is low on the cycles before and after. The hold check waits more than three idle cycles, so that all stages have drained, and only then compares the outputs with the last valid sample.

// File: rtl/sirds_sep_pkg.sv
package sirds_sep_pkg;

  // Number of register stages in the separation pipeline
  localparam int SEP_STAGES = 3;

  // Load strobes from control to datapath, one per stage
  typedef struct packed {
    logic ldCoord;   // stage 3: left/right coordinates
    logic ldSep;     // stage 2: divide
    logic ldNumDen;  // stage 1: numerator and denominator
  } sep_strobe_t;

endpackage

// File: rtl/sep_ctrl.sv
module sep_ctrl
  import sirds_sep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output sep_strobe_t strobe,
  output logic        outValid
);

  logic [SEP_STAGES-1:0] vldPipe;

  for (genvar g = 0; g < SEP_STAGES; g++) begin : g_vld
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vldPipe[0] <= 1'b0;
        else       vldPipe[0] <= inValid;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vldPipe[g] <= 1'b0;
        else       vldPipe[g] <= vldPipe[g-1];
      end
    end
  end

  // A stage loads on the cycle its input holds a valid sample
  always_comb begin
    strobe.ldNumDen = inValid;
    strobe.ldSep    = vldPipe[0];
    strobe.ldCoord  = vldPipe[1];
  end

  assign outValid = vldPipe[SEP_STAGES-1];

endmodule

// File: rtl/sep_datapath.sv
module sep_datapath
  import sirds_sep_pkg::*;
#(
  parameter int X_W          = 10,
  parameter int Y_W          = 9,
  parameter int Z_W          = 8,
  parameter int DIST_W       = 12,
  parameter int SEP_W        = 10,
  parameter int SCREEN_W     = 640,
  parameter int HEIGHT_SCALE = 1,
  parameter bit ROUND_SEP    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sep_strobe_t       strobe,
  input  logic [X_W-1:0]    inX,
  input  logic [Y_W-1:0]    inY,
  input  logic [Z_W-1:0]    inZ,
  input  logic [DIST_W-1:0] bgDepth,
  input  logic [DIST_W-1:0] obsDist,
  input  logic [SEP_W-1:0]  eyeSep,
  output logic [X_W-1:0]    outX,
  output logic [Y_W-1:0]    outY,
  output logic [Z_W-1:0]    outZ,
  output logic [SEP_W-1:0]  outSep,
  output logic [X_W-1:0]    outLeft,
  output logic [X_W-1:0]    outRight,
  output logic              outOfRange
);

  localparam int SCALED_W = Z_W + $clog2(HEIGHT_SCALE + 1);
  localparam int CMP_W    = (SCALED_W > DIST_W) ? SCALED_W : DIST_W;
  localparam int NUM_W    = DIST_W + SEP_W;
  localparam int DEN_W    = DIST_W + 1;
  localparam int DIV_W    = NUM_W + 1;
  localparam int COORD_W  = ((X_W > SEP_W) ? X_W : SEP_W) + 1;

  logic [SEP_STAGES-1:0] ld;
  assign ld = {strobe.ldCoord, strobe.ldSep, strobe.ldNumDen};

  // ---------------- sample fields carried beside the data ----------------
  logic [X_W-1:0] xPipe [SEP_STAGES];
  logic [Y_W-1:0] yPipe [SEP_STAGES];
  logic [Z_W-1:0] zPipe [SEP_STAGES];

  for (genvar g = 0; g < SEP_STAGES; g++) begin : g_carry
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          xPipe[0] <= '0;
          yPipe[0] <= '0;
          zPipe[0] <= '0;
        end else if (ld[0]) begin
          xPipe[0] <= inX;
          yPipe[0] <= inY;
          zPipe[0] <= inZ;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          xPipe[g] <= '0;
          yPipe[g] <= '0;
          zPipe[g] <= '0;
        end else if (ld[g]) begin
          xPipe[g] <= xPipe[g-1];
          yPipe[g] <= yPipe[g-1];
          zPipe[g] <= zPipe[g-1];
        end
      end
    end
  end

  // ---------------- stage 1: numerator and denominator ----------------
  logic [CMP_W-1:0]  scaledZ;
  logic [CMP_W-1:0]  bgWide;
  logic [DIST_W-1:0] depthBehind;
  logic [NUM_W-1:0]  numNext;
  logic [DEN_W-1:0]  denNext;
  logic [NUM_W-1:0]  numR;
  logic [DEN_W-1:0]  denR;

  always_comb begin
    scaledZ = CMP_W'(inZ) * CMP_W'(HEIGHT_SCALE);
    bgWide  = CMP_W'(bgDepth);
    if (bgWide > scaledZ) depthBehind = DIST_W'(bgWide - scaledZ);
    else                  depthBehind = '0;
    numNext = NUM_W'(depthBehind) * NUM_W'(eyeSep);
    denNext = DEN_W'(obsDist) + DEN_W'(depthBehind);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numR <= '0;
      denR <= '0;
    end else if (ld[0]) begin
      numR <= numNext;
      denR <= denNext;
    end
  end

  // ---------------- stage 2: divide ----------------
  logic [DIV_W-1:0] dividend;
  logic [DIV_W-1:0] quotient;
  logic [SEP_W-1:0] sepR;

  if (ROUND_SEP) begin : g_round
    assign dividend = DIV_W'(numR) + DIV_W'(denR >> 1);
  end else begin : g_trunc
    assign dividend = DIV_W'(numR);
  end

  always_comb begin
    if (denR == '0) quotient = '0;
    else            quotient = dividend / DIV_W'(denR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      sepR <= '0;
    else if (ld[1]) sepR <= SEP_W'(quotient);
  end

  // ---------------- stage 3: left / right coordinates ----------------
  logic [COORD_W-1:0] xWide;
  logic [COORD_W-1:0] halfWide;
  logic [COORD_W-1:0] rightWide;
  logic [COORD_W-1:0] leftWide;
  logic               oorNext;
  logic [SEP_W-1:0]   sepOutR;
  logic [X_W-1:0]     leftR;
  logic [X_W-1:0]     rightR;
  logic               oorR;

  always_comb begin
    xWide     = COORD_W'(xPipe[1]);
    halfWide  = COORD_W'(sepR >> 1);
    rightWide = xWide + halfWide;
    leftWide  = xWide - halfWide;
    oorNext   = (xWide < halfWide) || (rightWide > COORD_W'(SCREEN_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sepOutR <= '0;
      leftR   <= '0;
      rightR  <= '0;
      oorR    <= 1'b0;
    end else if (ld[2]) begin
      sepOutR <= sepR;
      leftR   <= X_W'(leftWide);
      rightR  <= X_W'(rightWide);
      oorR    <= oorNext;
    end
  end

  assign outX       = xPipe[SEP_STAGES-1];
  assign outY       = yPipe[SEP_STAGES-1];
  assign outZ       = zPipe[SEP_STAGES-1];
  assign outSep     = sepOutR;
  assign outLeft    = leftR;
  assign outRight   = rightR;
  assign outOfRange = oorR;

endmodule

// File: rtl/stereo_sep_calc.sv
module stereo_sep_calc
  import sirds_sep_pkg::*;
#(
  parameter int X_W          = 10,
  parameter int Y_W          = 9,
  parameter int Z_W          = 8,
  parameter int DIST_W       = 12,
  parameter int SEP_W        = 10,
  parameter int SCREEN_W     = 640,
  parameter int HEIGHT_SCALE = 1,
  parameter bit ROUND_SEP    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [X_W-1:0]    inX,
  input  logic [Y_W-1:0]    inY,
  input  logic [Z_W-1:0]    inZ,
  input  logic [DIST_W-1:0] bgDepth,
  input  logic [DIST_W-1:0] obsDist,
  input  logic [SEP_W-1:0]  eyeSep,
  output logic              outValid,
  output logic [X_W-1:0]    outX,
  output logic [Y_W-1:0]    outY,
  output logic [Z_W-1:0]    outZ,
  output logic [SEP_W-1:0]  outSep,
  output logic [X_W-1:0]    outLeft,
  output logic [X_W-1:0]    outRight,
  output logic              outOfRange
);

  sep_strobe_t strobe;

  sep_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sep_datapath #(
    .X_W          (X_W),
    .Y_W          (Y_W),
    .Z_W          (Z_W),
    .DIST_W       (DIST_W),
    .SEP_W        (SEP_W),
    .SCREEN_W     (SCREEN_W),
    .HEIGHT_SCALE (HEIGHT_SCALE),
    .ROUND_SEP    (ROUND_SEP)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inX        (inX),
    .inY        (inY),
    .inZ        (inZ),
    .bgDepth    (bgDepth),
    .obsDist    (obsDist),
    .eyeSep     (eyeSep),
    .outX       (outX),
    .outY       (outY),
    .outZ       (outZ),
    .outSep     (outSep),
    .outLeft    (outLeft),
    .outRight   (outRight),
    .outOfRange (outOfRange)
  );

endmodule

// File: rtl/stereo_sep_calc_chk.sv
module stereo_sep_calc_chk #(
  parameter int X_W      = 10,
  parameter int Y_W      = 9,
  parameter int Z_W      = 8,
  parameter int SEP_W    = 10,
  parameter int SCREEN_W = 640
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [X_W-1:0]   inX,
  input logic [Y_W-1:0]   inY,
  input logic [Z_W-1:0]   inZ,
  input logic [SEP_W-1:0] eyeSep,
  input logic             outValid,
  input logic [X_W-1:0]   outX,
  input logic [Y_W-1:0]   outY,
  input logic [Z_W-1:0]   outZ,
  input logic [SEP_W-1:0] outSep,
  input logic [X_W-1:0]   outLeft,
  input logic [X_W-1:0]   outRight,
  input logic             outOfRange
);

  // Cycles since reset, saturating at 3, so $past(...,3) never reaches into reset
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!outValid && outSep == '0 && !outOfRange)); // R1

  AST_SEP_NOT_ABOVE_EYE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid) |-> (outSep <= $past(eyeSep, 3))); // R2

  AST_PAIR_SYMMETRIC: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outOfRange) |-> (X_W'(outRight - outX) == X_W'(outX - outLeft))); // R3

  AST_PAIR_ON_SCREEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outOfRange) |-> (outRight <= X_W'(SCREEN_W - 1) && outLeft <= outX)); // R4

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3))); // R5

  AST_FIELDS_CARRIED: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid) |->
      (outX == $past(inX, 3) && outY == $past(inY, 3) && outZ == $past(inZ, 3))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !$past(inValid, 3)) |->
      ($stable(outSep) && $stable(outX) && $stable(outLeft) && $stable(outRight))); // R8

endmodule

bind stereo_sep_calc stereo_sep_calc_chk #(
  .X_W      (X_W),
  .Y_W      (Y_W),
  .Z_W      (Z_W),
  .SEP_W    (SEP_W),
  .SCREEN_W (SCREEN_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inX        (inX),
  .inY        (inY),
  .inZ        (inZ),
  .eyeSep     (eyeSep),
  .outValid   (outValid),
  .outX       (outX),
  .outY       (outY),
  .outZ       (outZ),
  .outSep     (outSep),
  .outLeft    (outLeft),
  .outRight   (outRight),
  .outOfRange (outOfRange)
);

// File: tb/test_stereo_sep_calc.sv
module test_stereo_sep_calc;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 11;

  // Columns: x, y, z, sep, left, right, outOfRange (left/right unused when flag is 1)
  // Settings for the table: bgDepth 200, obsDist 400, eyeSep 120, scale 1
  localparam int VEC [NVEC][7] = '{
    '{100,  5,   0, 40,  80, 120, 0},  // background: widest sep (R7)
    '{300,  6, 100, 24, 288, 312, 0},
    '{  0,  7, 200,  0,   0,   0, 0},  // depth exactly 0 (R7)
    '{639,  8, 255,  0, 639, 639, 0},  // height beyond depth clamps (R7)
    '{ 10,  9,   0, 40,   0,   0, 1},  // left off screen (R4)
    '{630, 10,  50, 33,   0,   0, 1},  // right off screen (R4)
    '{623, 11,  50, 33, 607, 639, 0},  // right exactly on last column (R4)
    '{ 19, 12,  10, 39,   0,  38, 0},  // left exactly column 0 (R4)
    '{ 18, 13,  10, 39,   0,   0, 1},  // one column short (R4)
    '{400, 14, 150, 13, 394, 406, 0},  // rounding down 13.33 (R2)
    '{ 50, 15, 175,  7,  47,  53, 0}   // rounding 7.06 (R2)
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [9:0]  inX = '0;
  logic [8:0]  inY = '0;
  logic [7:0]  inZ = '0;
  logic [11:0] bgDepth = 12'd200;
  logic [11:0] obsDist = 12'd400;
  logic [9:0]  eyeSep = 10'd120;
  logic        outValid;
  logic [9:0]  outX;
  logic [8:0]  outY;
  logic [7:0]  outZ;
  logic [9:0]  outSep;
  logic [9:0]  outLeft;
  logic [9:0]  outRight;
  logic        outOfRange;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_sep_calc i_stereo_sep_calc (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inX(inX), .inY(inY), .inZ(inZ),
    .bgDepth(bgDepth), .obsDist(obsDist), .eyeSep(eyeSep),
    .outValid(outValid), .outX(outX), .outY(outY), .outZ(outZ), .outSep(outSep),
    .outLeft(outLeft), .outRight(outRight), .outOfRange(outOfRange)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int x, input int y, input int z);
    inValid = v;
    inX = 10'(x);
    inY = 9'(y);
    inZ = 8'(z);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1 (run did not finish)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outValid", int'(outValid), 0);
    check("R1 outSep", int'(outSep), 0);
    check("R1 outX", int'(outX), 0);
    check("R1 outRight", int'(outRight), 0);
    check("R1 outOfRange", int'(outOfRange), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R7: back-to-back stream, result sampled 3 falling edges later
    for (int i = 0; i < NVEC + 3; i++) begin
      if (i >= 3) begin
        check("R5 outValid", int'(outValid), 1);
        check("R6 outX", int'(outX), VEC[i-3][0]);
        check("R6 outY", int'(outY), VEC[i-3][1]);
        check("R6 outZ", int'(outZ), VEC[i-3][2]);
        check("R2 outSep", int'(outSep), VEC[i-3][3]);
        check("R4 outOfRange", int'(outOfRange), VEC[i-3][6]);
        if (VEC[i-3][6] == 0) begin
          check("R3 outLeft", int'(outLeft), VEC[i-3][4]);
          check("R3 outRight", int'(outRight), VEC[i-3][5]);
        end
      end
      if (i < NVEC) drive(1'b1, VEC[i][0], VEC[i][1], VEC[i][2]);
      else          drive(1'b0, 777, 300, 99);
      @(negedge clk);
    end

    // R8: idle cycles with other data on the inputs leave the last result
    drive(1'b0, 3, 4, 5);
    repeat (5) @(negedge clk);
    check("R5 outValid idle", int'(outValid), 0);
    check("R8 outSep hold", int'(outSep), 7);
    check("R8 outX hold", int'(outX), 50);
    check("R8 outLeft hold", int'(outLeft), 47);
    check("R8 outRight hold", int'(outRight), 53);

    // R2 R5: other settings, single pulse, latency exactly 3
    bgDepth = 12'd100;
    obsDist = 12'd100;
    eyeSep  = 10'd64;
    repeat (4) @(negedge clk);
    drive(1'b1, 320, 100, 0);
    @(negedge clk);
    drive(1'b0, 0, 0, 0);
    check("R5 pulse +1", int'(outValid), 0);
    @(negedge clk);
    check("R5 pulse +2", int'(outValid), 0);
    @(negedge clk);
    check("R5 pulse +3", int'(outValid), 1);
    check("R2 outSep 32", int'(outSep), 32);
    check("R3 outLeft 304", int'(outLeft), 304);
    check("R3 outRight 336", int'(outRight), 336);
    @(negedge clk);
    check("R5 pulse +4", int'(outValid), 0);

    // R2: zero denominator gives zero separation
    bgDepth = 12'd0;
    obsDist = 12'd0;
    repeat (4) @(negedge clk);
    drive(1'b1, 200, 1, 0);
    @(negedge clk);
    drive(1'b0, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R2 zero den sep", int'(outSep), 0);
    check("R7 zero sep left", int'(outLeft), 200);

    // R1: reset taken mid-stream clears the outputs at once
    bgDepth = 12'd200;
    obsDist = 12'd400;
    eyeSep  = 10'd120;
    drive(1'b1, 100, 2, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 mid outValid", int'(outValid), 0);
    check("R1 mid outSep", int'(outSep), 0);
    check("R1 mid outX", int'(outX), 0);
    drive(1'b0, 0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", int'(outValid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule